// File: doc/BRIEF.md
# Host-Target Mailbox Console

This block is a pair of 64-bit mailbox registers that a 32-bit CPU bus reaches as word halves. The command mailbox carries target-to-host requests and the response mailbox carries host-to-target replies. Once a full 64-bit command has been assembled, the block splits it into an 8-bit device selector, an 8-bit command selector and a 48-bit payload. It then carries out one of three actions: it sends a character to a console output stream, it parks a character request until an input byte arrives, or it signals a program exit with an exit code.

The command mailbox has a lockout. The low half is taken only while the whole register is zero. Only a write of the high half, and only after an accepted low-half write, starts execution. Every reply keeps the upper 16 bits of the command that caused it. This lets the target match a reply to its request.

Top module: `htlink_mailbox`

## Requirements
- R1: A command with device 1 and command 1 (device in bits 63:56, command in bits 55:48) drives payload bits 7:0 on `conOutData` with `conOutValid` high. Both stay stable until `conOutReady` is seen high at a clock edge.
- R2: On the put handshake edge, the response mailbox becomes {command bits 63:48, 48'h100 | byte} and the command mailbox becomes zero.
- R3: A write to the command low half (offset 0x0) loads bits 31:0 and arms the high half only when the whole command mailbox is zero. Otherwise the write is ignored and the high half is disarmed, so later high-half writes are ignored as well.
- R4: An armed write to the command high half (offset 0x4) ORs the data into bits 63:32 and starts execution. Any command-mailbox write while a command is executing or waiting on the console is ignored.
- R5: A command with device 1 and command 0 saves the command as the pending read and clears the command mailbox. It leaves the response mailbox unchanged and produces no console output.
- R6: A cycle with `conInValid` high sets the response mailbox to {pending command bits 63:48, 48'h100 | `conInData`}.
- R7: A command with device 0, command 0 and payload bit 0 set gives a one-cycle `exitPulse` with `exitCode` = payload bits 47:1. The response mailbox becomes {command bits 63:48, 48'h0} and the command mailbox is cleared.
- R8: Any other command gives a one-cycle `errPulse`. It also sets the response mailbox to {command bits 63:48, 48'h0} and clears the command mailbox.
- R9: A CPU write to the response low half (offset 0x8) replaces the whole register with the zero-extended data. A write to the response high half (offset 0xC) ORs the data into bits 63:32.
- R10: Reads at 0x0, 0x4, 0x8 and 0xC return the command low, command high, response low and response high words. Any other offset reads zero, and writes to it change nothing.
- R11: When more than one source writes the response mailbox in the same cycle, a command response wins over an input character, and an input character wins over a CPU write.
- R12: After reset both mailboxes read zero and `conOutValid`, `exitPulse` and `errPulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access strobe |
| busWe | input | 1 | Write enable (with busSel) |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| conOutValid | output | 1 | Console output byte valid |
| conOutReady | input | 1 | Console output sink ready |
| conOutData | output | 8 | Console output byte |
| conInValid | input | 1 | Console input byte present (always accepted) |
| conInData | input | 8 | Console input byte |
| exitPulse | output | 1 | One-cycle exit request |
| exitCode | output | 47 | Exit code, valid with exitPulse |
| errPulse | output | 1 | One-cycle unknown-command indication |

## Verification
The put path is swept over all 256 byte values, with console stall lengths from zero to two cycles. This tells apart a byte taken from the wrong payload bits and a stream that moves before the handshake. The get path is swept over all 256 input characters after a parked request, which exposes a wrong reply tag or a wrong 0x100 marker. Exit codes with scattered bit patterns separate a correct shift by one from an unshifted or truncated code. Four malformed commands (wrong device, wrong command, even payload, odd payload on a foreign command) must all take the error path and none the exit path. Targeted sequences cover the lockout, high-half writes made during a console stall, OR-merging of the response halves, unmapped offsets and response-source priority.

// File: rtl/htlink_pkg.sv
package htlink_pkg;

  localparam int BUS_W     = 32;
  localparam int REG_W     = 2 * BUS_W;
  localparam int CHAR_W    = 8;
  localparam int SEL_W     = 8;
  localparam int TAG_W     = 2 * SEL_W;
  localparam int PAYLOAD_W = REG_W - TAG_W;
  localparam int CODE_W    = PAYLOAD_W - 1;

  localparam logic [SEL_W-1:0] DEV_SYSTEM  = 8'd0;
  localparam logic [SEL_W-1:0] DEV_CONSOLE = 8'd1;
  localparam logic [SEL_W-1:0] CMD_GET     = 8'd0;
  localparam logic [SEL_W-1:0] CMD_PUT     = 8'd1;
  localparam logic [SEL_W-1:0] CMD_SYS     = 8'd0;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_PUT  = 2'd2
  } mbxState_t;

  typedef struct packed {
    logic toLoLoad;
    logic toLoReject;
    logic toHiOr;
    logic toClear;
    logic pendLoad;
    logic respLoad;
    logic respPut;
    logic fhLoLoad;
    logic fhHiOr;
  } mbxStrobe_t;

endpackage

// File: rtl/htlink_ctrl.sv
module htlink_ctrl
  import htlink_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int TO_OFS   = 0,
  parameter int FROM_OFS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              toIsZero,
  input  logic              allowFlag,
  input  logic [SEL_W-1:0]  devField,
  input  logic [SEL_W-1:0]  cmdField,
  input  logic              payloadBit0,
  input  logic              conOutReady,
  output mbxStrobe_t        strobe,
  output logic              conOutValid,
  output logic              exitPulse,
  output logic              errPulse
);

  localparam logic [ADDR_W-1:0] A_TO_LO = ADDR_W'(TO_OFS);
  localparam logic [ADDR_W-1:0] A_TO_HI = ADDR_W'(TO_OFS + 4);
  localparam logic [ADDR_W-1:0] A_FH_LO = ADDR_W'(FROM_OFS);
  localparam logic [ADDR_W-1:0] A_FH_HI = ADDR_W'(FROM_OFS + 4);

  mbxState_t state, stateNext;

  logic wrEn, isIdle, isPut, isGet, isExit;

  assign wrEn   = busSel && busWe;
  assign isIdle = (state == ST_IDLE);
  assign isPut  = (devField == DEV_CONSOLE) && (cmdField == CMD_PUT);
  assign isGet  = (devField == DEV_CONSOLE) && (cmdField == CMD_GET);
  assign isExit = (devField == DEV_SYSTEM) && (cmdField == CMD_SYS) && payloadBit0;

  always_comb begin
    strobe      = '0;
    stateNext   = state;
    conOutValid = 1'b0;
    exitPulse   = 1'b0;
    errPulse    = 1'b0;

    strobe.toLoLoad   = wrEn && (busAddr == A_TO_LO) && isIdle && toIsZero;
    strobe.toLoReject = wrEn && (busAddr == A_TO_LO) && isIdle && !toIsZero;
    strobe.toHiOr     = wrEn && (busAddr == A_TO_HI) && isIdle && allowFlag;
    strobe.fhLoLoad   = wrEn && (busAddr == A_FH_LO);
    strobe.fhHiOr     = wrEn && (busAddr == A_FH_HI);

    unique case (state)
      ST_IDLE: begin
        if (strobe.toHiOr) stateNext = ST_EXEC;
      end
      ST_EXEC: begin
        if (isPut) begin
          stateNext = ST_PUT;
        end else if (isGet) begin
          strobe.pendLoad = 1'b1;
          strobe.toClear  = 1'b1;
          stateNext       = ST_IDLE;
        end else begin
          strobe.respLoad = 1'b1;
          strobe.toClear  = 1'b1;
          exitPulse       = isExit;
          errPulse        = !isExit;
          stateNext       = ST_IDLE;
        end
      end
      ST_PUT: begin
        conOutValid = 1'b1;
        if (conOutReady) begin
          strobe.respLoad = 1'b1;
          strobe.respPut  = 1'b1;
          strobe.toClear  = 1'b1;
          stateNext       = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/htlink_dpath.sv
module htlink_dpath
  import htlink_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int TO_OFS   = 0,
  parameter int FROM_OFS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbxStrobe_t        strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic              conInValid,
  input  logic [CHAR_W-1:0] conInData,
  output logic              toIsZero,
  output logic              allowFlag,
  output logic [SEL_W-1:0]  devField,
  output logic [SEL_W-1:0]  cmdField,
  output logic              payloadBit0,
  output logic [CHAR_W-1:0] conOutData,
  output logic [CODE_W-1:0] exitCode,
  output logic [REG_W-1:0]  toWord,
  output logic [REG_W-1:0]  fromWord
);

  localparam logic [ADDR_W-1:0] A_TO_LO = ADDR_W'(TO_OFS);
  localparam logic [ADDR_W-1:0] A_TO_HI = ADDR_W'(TO_OFS + 4);
  localparam logic [ADDR_W-1:0] A_FH_LO = ADDR_W'(FROM_OFS);
  localparam logic [ADDR_W-1:0] A_FH_HI = ADDR_W'(FROM_OFS + 4);
  localparam logic [PAYLOAD_W-1:0] MARK = PAYLOAD_W'(1) << CHAR_W;

  logic [REG_W-1:0]     pendWord;
  logic [PAYLOAD_W-1:0] putResp;
  logic [PAYLOAD_W-1:0] getResp;

  assign putResp = MARK | PAYLOAD_W'(toWord[CHAR_W-1:0]);
  assign getResp = MARK | PAYLOAD_W'(conInData);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toWord    <= '0;
      allowFlag <= 1'b0;
    end else begin
      if (strobe.toClear)
        toWord <= '0;
      else if (strobe.toLoLoad)
        toWord <= {{BUS_W{1'b0}}, busWdata};
      else if (strobe.toHiOr)
        toWord[REG_W-1:BUS_W] <= toWord[REG_W-1:BUS_W] | busWdata;

      if (strobe.toLoLoad)        allowFlag <= 1'b1;
      else if (strobe.toLoReject) allowFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                pendWord <= '0;
    else if (strobe.pendLoad) pendWord <= toWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fromWord <= '0;
    end else if (strobe.respLoad) begin
      fromWord <= {toWord[REG_W-1:PAYLOAD_W], strobe.respPut ? putResp : '0};
    end else if (conInValid) begin
      fromWord <= {pendWord[REG_W-1:PAYLOAD_W], getResp};
    end else if (strobe.fhLoLoad) begin
      fromWord <= {{BUS_W{1'b0}}, busWdata};
    end else if (strobe.fhHiOr) begin
      fromWord[REG_W-1:BUS_W] <= fromWord[REG_W-1:BUS_W] | busWdata;
    end
  end

  always_comb begin
    unique case (busAddr)
      A_TO_LO: busRdata = toWord[BUS_W-1:0];
      A_TO_HI: busRdata = toWord[REG_W-1:BUS_W];
      A_FH_LO: busRdata = fromWord[BUS_W-1:0];
      A_FH_HI: busRdata = fromWord[REG_W-1:BUS_W];
      default: busRdata = '0;
    endcase
  end

  assign toIsZero    = (toWord == '0);
  assign devField    = toWord[REG_W-1 -: SEL_W];
  assign cmdField    = toWord[REG_W-SEL_W-1 -: SEL_W];
  assign payloadBit0 = toWord[0];
  assign conOutData  = toWord[CHAR_W-1:0];
  assign exitCode    = toWord[PAYLOAD_W-1:1];

endmodule

// File: rtl/htlink_mailbox.sv
module htlink_mailbox
  import htlink_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int TO_OFS   = 0,
  parameter int FROM_OFS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              conOutValid,
  input  logic              conOutReady,
  output logic [7:0]        conOutData,
  input  logic              conInValid,
  input  logic [7:0]        conInData,
  output logic              exitPulse,
  output logic [46:0]       exitCode,
  output logic              errPulse
);

  mbxStrobe_t       strobe;
  logic             toIsZero, allowFlag, payloadBit0;
  logic [SEL_W-1:0] devField, cmdField;
  logic [REG_W-1:0] toWord, fromWord;

  htlink_ctrl #(.ADDR_W(ADDR_W), .TO_OFS(TO_OFS), .FROM_OFS(FROM_OFS)) ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .toIsZero(toIsZero), .allowFlag(allowFlag), .devField(devField),
    .cmdField(cmdField), .payloadBit0(payloadBit0), .conOutReady(conOutReady),
    .strobe(strobe), .conOutValid(conOutValid), .exitPulse(exitPulse),
    .errPulse(errPulse)
  );

  htlink_dpath #(.ADDR_W(ADDR_W), .TO_OFS(TO_OFS), .FROM_OFS(FROM_OFS)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .conInValid(conInValid),
    .conInData(conInData), .toIsZero(toIsZero), .allowFlag(allowFlag),
    .devField(devField), .cmdField(cmdField), .payloadBit0(payloadBit0),
    .conOutData(conOutData), .exitCode(exitCode), .toWord(toWord),
    .fromWord(fromWord)
  );

endmodule

// File: rtl/htlink_mailbox_chk.sv
module htlink_mailbox_chk (
  input logic        clk,
  input logic        rstN,
  input logic        conOutValid,
  input logic        conOutReady,
  input logic [7:0]  conOutData,
  input logic        exitPulse,
  input logic        errPulse,
  input logic [63:0] toWord,
  input logic [63:0] fromWord
);

  p_out_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    conOutValid && !conOutReady |=> conOutValid && $stable(conOutData));

  p_put_resp_r2: assert property (@(posedge clk) disable iff (!rstN)
    conOutValid && conOutReady |=>
      (fromWord[47:0] == {39'h0, 1'b1, $past(conOutData)}) && (toWord == 64'h0));

  p_exit_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    exitPulse |=> !exitPulse && (toWord == 64'h0) && (fromWord[47:0] == 48'h0));

  p_exit_no_out_r7: assert property (@(posedge clk) disable iff (!rstN)
    exitPulse |-> !conOutValid && !errPulse);

  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> !errPulse && (toWord == 64'h0) && (fromWord[47:0] == 48'h0));

endmodule

bind htlink_mailbox htlink_mailbox_chk chk_i (
  .clk(clk), .rstN(rstN), .conOutValid(conOutValid), .conOutReady(conOutReady),
  .conOutData(conOutData), .exitPulse(exitPulse), .errPulse(errPulse),
  .toWord(toWord), .fromWord(fromWord)
);

// File: tb/htlink_mailbox_tb.sv
module htlink_mailbox_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWe = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        conOutValid, conOutReady = 1'b0;
  logic [7:0]  conOutData;
  logic        conInValid = 1'b0;
  logic [7:0]  conInData = '0;
  logic        exitPulse, errPulse;
  logic [46:0] exitCode;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  htlink_mailbox dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .conOutValid(conOutValid),
    .conOutReady(conOutReady), .conOutData(conOutData), .conInValid(conInValid),
    .conInData(conInData), .exitPulse(exitPulse), .exitCode(exitCode),
    .errPulse(errPulse)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic readWord(input logic [4:0] base, output logic [63:0] w);
    logic [31:0] lo, hi;
    busRead(base, lo);
    busRead(base + 5'd4, hi);
    w = {hi, lo};
  endtask

  task automatic sendCmd(input logic [63:0] c);
    busWrite(5'h0, c[31:0]);
    busWrite(5'h4, c[63:32]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] w;
    logic [31:0] r;
    doReset();

    // R12 reset state
    readWord(5'h0, w); check("R12 tohost", w, 64'h0);
    readWord(5'h8, w); check("R12 fromhost", w, 64'h0);
    check("R12 outputs", {61'h0, conOutValid, exitPulse, errPulse}, 64'h0);

    // R1 R2 put sweep over every byte with 0..2 stall cycles
    for (int c = 0; c < 256; c++) begin
      logic [63:0] cmd;
      cmd = {16'h0101, 16'(c * 3), 8'(c ^ 8'h3C), 16'h1234, 8'(c)};
      sendCmd(cmd);
      @(negedge clk);
      check("R1 valid", {63'h0, conOutValid}, 64'h1);
      check("R1 data", {56'h0, conOutData}, {56'h0, 8'(c)});
      for (int s = 0; s < c % 3; s++) begin
        @(negedge clk);
        check("R1 hold", {55'h0, conOutValid, conOutData}, {55'h0, 1'b1, 8'(c)});
      end
      conOutReady = 1'b1;
      @(negedge clk);
      conOutReady = 1'b0;
      check("R1 drop", {63'h0, conOutValid}, 64'h0);
      readWord(5'h8, w); check("R2 resp", w, {16'h0101, 40'h1, 8'(c)});
      readWord(5'h0, w); check("R2 clear", w, 64'h0);
    end

    // R4 high-half write during a console stall is ignored
    sendCmd({16'h0101, 40'h0, 8'h41});
    @(negedge clk);
    busWrite(5'h4, 32'hFFFF_0000);
    readWord(5'h0, w); check("R4 busy ignore", w, {16'h0101, 40'h0, 8'h41});
    conOutReady = 1'b1;
    @(negedge clk);
    conOutReady = 1'b0;
    readWord(5'h8, w); check("R4 resp tag", w, {16'h0101, 40'h1, 8'h41});

    // R7 exit codes
    for (int i = 0; i < 16; i++) begin
      logic [46:0] code;
      logic [47:0] pl;
      code = 47'(64'(i) * 64'h9E37_79B9_7F4A_7C15) ^ 47'(i << 40);
      pl = {code, 1'b1};
      sendCmd({16'h0000, pl});
      check("R7 pulse", {62'h0, exitPulse, errPulse}, 64'h2);
      check("R7 code", {17'h0, exitCode}, {17'h0, code});
      @(negedge clk);
      check("R7 single", {63'h0, exitPulse}, 64'h0);
      readWord(5'h8, w); check("R7 resp", w, 64'h0);
      readWord(5'h0, w); check("R7 clear", w, 64'h0);
    end

    // R8 error commands
    for (int k = 0; k < 4; k++) begin
      logic [63:0] cmd;
      case (k)
        0: cmd = 64'h0207_0000_0000_1235;
        1: cmd = 64'h0105_0000_0000_0041;
        2: cmd = 64'h0000_0000_0000_0010;
        default: cmd = 64'h0003_0000_0000_0001;
      endcase
      sendCmd(cmd);
      check("R8 pulse", {62'h0, exitPulse, errPulse}, 64'h1);
      @(negedge clk);
      check("R8 single", {63'h0, errPulse}, 64'h0);
      readWord(5'h8, w); check("R8 resp", w, {cmd[63:48], 48'h0});
      readWord(5'h0, w); check("R8 clear", w, 64'h0);
    end

    // R5 get, then R6 input sweep
    busWrite(5'h8, 32'h1111);
    sendCmd(64'h0100_0000_0000_0000);
    @(negedge clk);
    readWord(5'h0, w); check("R5 clear", w, 64'h0);
    readWord(5'h8, w); check("R5 resp kept", w, 64'h1111);
    check("R5 no out", {63'h0, conOutValid}, 64'h0);
    for (int c = 0; c < 256; c++) begin
      conInValid = 1'b1; conInData = 8'(c);
      @(negedge clk);
      conInValid = 1'b0;
      readWord(5'h8, w); check("R6 input", w, {16'h0100, 40'h1, 8'(c)});
    end

    // R11 input char beats a CPU write
    conInValid = 1'b1; conInData = 8'h7E;
    busWrite(5'h8, 32'hDEAD_BEEF);
    conInValid = 1'b0;
    readWord(5'h8, w); check("R11 priority", w, {16'h0100, 40'h1, 8'h7E});

    // R9 response halves
    busWrite(5'h8, 32'hAAAA_0001);
    busWrite(5'hC, 32'h0F00_0000);
    readWord(5'h8, w); check("R9 load", w, 64'h0F00_0000_AAAA_0001);
    busWrite(5'hC, 32'h0000_00F0);
    readWord(5'h8, w); check("R9 or", w, 64'h0F00_00F0_AAAA_0001);
    busWrite(5'h8, 32'h5);
    readWord(5'h8, w); check("R9 low replaces", w, 64'h5);

    // R10 unmapped offsets
    busWrite(5'h10, 32'hFFFF_FFFF);
    busWrite(5'h14, 32'hFFFF_FFFF);
    busRead(5'h10, r); check("R10 unmapped read", {32'h0, r}, 64'h0);
    busRead(5'h1C, r); check("R10 unmapped read hi", {32'h0, r}, 64'h0);
    readWord(5'h0, w); check("R10 tohost untouched", w, 64'h0);
    readWord(5'h8, w); check("R10 fromhost untouched", w, 64'h5);

    // R3 lockout
    busWrite(5'h0, 32'h0000_00AA);
    busWrite(5'h0, 32'h0000_0055);
    readWord(5'h0, w); check("R3 reject", w, 64'hAA);
    busWrite(5'h4, 32'h0101_0000);
    @(negedge clk);
    readWord(5'h0, w); check("R3 disarmed", w, 64'hAA);
    check("R3 no action", {62'h0, conOutValid, errPulse}, 64'h0);
    doReset();
    readWord(5'h0, w); check("R12 after reset", w, 64'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule